// File: doc/BRIEF.md
# Quadrature Encoder Edge Decoder

This block turns the two phase-shifted outputs of an incremental quadrature encoder into the step events that a position counter needs. Both channel inputs are brought into the system clock domain through a chain of synchronising flops. Each change of a synchronised channel then counts as an edge. For every edge that the current mode accepts, the block raises a one-cycle count strobe. In the same cycle it reports whether the step is up or down.

A 2-bit mode select picks the edges that count. The block can count on channel 2 edges only, on channel 1 edges only, or on the edges of both channels, which gives four counts per encoder cycle. A fourth code stops all counting. The direction of an edge comes from the new level of the channel that moved, compared with the level of the other channel. The convention is chosen so that one steady rotation gives the same direction on every edge, and a counter driven by the strobe therefore follows the shaft angle. If both channels change in the same sampled cycle, the phase relation is lost. The block drops that transition and sets a sticky error flag.

Top module: `qenc_decoder`

## Requirements
- R1: After a synchronous reset, `cnt_stb`, `cnt_up` and `err_flag` are all 0.
- R2: With `mode_sel` = 2'b01, every change of channel 2 alone gives one strobe, and a change of channel 1 alone gives none.
- R3: With `mode_sel` = 2'b10, every change of channel 1 alone gives one strobe, and a change of channel 2 alone gives none.
- R4: With `mode_sel` = 2'b11, every change of either channel alone gives one strobe.
- R5: With `mode_sel` = 2'b00, no input change gives a strobe.
- R6: Direction: for a channel 1 edge, `cnt_up` is 1 when the new channel 1 level differs from channel 2. For a channel 2 edge, `cnt_up` is 1 when the new channel 2 level equals channel 1. `cnt_up` keeps its value between strobes.
- R7: A strobe is high for exactly one cycle. It appears on the (SYNC_STAGES+1)-th rising clock edge after the input change, and `cnt_up` is valid in that cycle.
- R8: When both channels change in the same sampled cycle, no strobe is produced in any mode, and `err_flag` rises in the cycle where the strobe would have appeared.
- R9: `err_flag` stays 1 until reset, whatever the later input activity.
- R10: In mode 2'b11, each full forward encoder cycle (ch1,ch2 = 00, 10, 11, 01, 00) gives four up strobes, and the reverse order gives four down strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ch1_in | input | 1 | Raw encoder channel 1 |
| ch2_in | input | 1 | Raw encoder channel 2 |
| mode_sel | input | 2 | Edge mode: 00 off, 01 ch2 edges, 10 ch1 edges, 11 both |
| cnt_stb | output | 1 | One-cycle count strobe |
| cnt_up | output | 1 | Step direction, 1 = up |
| err_flag | output | 1 | Sticky flag for a transition in which both channels changed |

## Verification
The bench builds the block with the default SYNC_STAGES of 2, so each input change reaches the strobe after three clock edges. This short latency makes it cheap to step through every mode, every start state of the two channels and every single-channel move from that state. For each step the bench checks that the strobe is absent before its cycle, present in that cycle with the expected direction, and absent in the cycle after. Separate sequences rotate the encoder forwards and backwards to check that the accumulated position comes out right, and apply a double change to check the error flag, that it stays set, and that reset clears it.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    // Bit 1 enables channel 1 edges, bit 0 enables channel 2 edges.
    typedef enum logic [1:0] {
        QM_IDLE = 2'b00,
        QM_CH2  = 2'b01,
        QM_CH1  = 2'b10,
        QM_BOTH = 2'b11
    } qmode_e;

    typedef struct packed {
        logic ch1;
        logic ch2;
    } qpair_t;

    typedef struct packed {
        logic hit;
        logic up;
        logic bad;
    } qevt_t;

    // Decide on count, direction and error from the old and new channel levels.
    function automatic qevt_t classify(qmode_e m, qpair_t old_v, qpair_t new_v);
        qevt_t  r;
        qpair_t d;
        r = '0;
        d = old_v ^ new_v;
        if (d.ch1 && d.ch2) begin
            r.bad = 1'b1;
        end else if (d.ch1) begin
            r.hit = m[1];
            r.up  = new_v.ch1 ^ new_v.ch2;
        end else if (d.ch2) begin
            r.hit = m[0];
            r.up  = ~(new_v.ch2 ^ new_v.ch1);
        end
        return r;
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= '0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q_out = chain[LAST];
endmodule

// File: rtl/qenc_edge.sv
module qenc_edge
    import qenc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  qpair_t cur,
    output qpair_t prev,
    output logic   edge1,
    output logic   edge2
);
    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    assign edge1 = cur.ch1 ^ prev.ch1;
    assign edge2 = cur.ch2 ^ prev.ch2;
endmodule

// File: rtl/qenc_decoder.sv
module qenc_decoder
    import qenc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ch1_in,
    input  logic       ch2_in,
    input  logic [1:0] mode_sel,
    output logic       cnt_stb,
    output logic       cnt_up,
    output logic       err_flag
);
    qpair_t raw;
    qpair_t cur;
    qpair_t prev;
    logic   e1;
    logic   e2;
    qevt_t  evt;

    assign raw.ch1 = ch1_in;
    assign raw.ch2 = ch2_in;

    qenc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw),
        .q_out (cur)
    );

    qenc_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .cur   (cur),
        .prev  (prev),
        .edge1 (e1),
        .edge2 (e2)
    );

    always_comb evt = classify(qmode_e'(mode_sel), prev, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_stb  <= 1'b0;
            cnt_up   <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            cnt_stb <= evt.hit;
            if (evt.hit) cnt_up   <= evt.up;
            if (evt.bad) err_flag <= 1'b1;
        end
    end

    // R5: the off code never produces a strobe
    assert_idle_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00) |=> !cnt_stb);

    // R3: channel 1 mode counts only when channel 1 moved
    assert_ch1_only_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b10 && !e1) |=> !cnt_stb);

    // R2: channel 2 mode counts only when channel 2 moved
    assert_ch2_only_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b01 && !e2) |=> !cnt_stb);

    // R8: a double change is dropped and flagged
    assert_double_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (e1 && e2) |=> (!cnt_stb && err_flag));

    // R9: the error flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R4: with both channels enabled, any single edge counts
    assert_both_count_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11 && (e1 ^ e2)) |=> cnt_stb);
endmodule

// File: tb/qenc_decoder_tb_top.sv
`timescale 1ns/1ps
module qenc_decoder_tb_top;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ch1 = 1'b0;
    logic       ch2 = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       cnt_stb;
    logic       cnt_up;
    logic       err_flag;

    int checks = 0;
    int fails  = 0;
    int pos    = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    qenc_decoder #(.SYNC_STAGES(SYNC)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .ch1_in   (ch1),
        .ch2_in   (ch2),
        .mode_sel (mode),
        .cnt_stb  (cnt_stb),
        .cnt_up   (cnt_up),
        .err_flag (err_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R5";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Spec model: which edges count and in which direction.
    task automatic model(input logic [1:0] m, input logic oa, input logic ob,
                         input logic na, input logic nb, output bit hit, output bit up);
        hit = 0; up = 0;
        if ((oa != na) && (ob == nb)) begin
            hit = m[1];
            up  = (na != nb);
        end else if ((ob != nb) && (oa == na)) begin
            hit = m[0];
            up  = (nb == na);
        end
    endtask

    task automatic step(input logic na, input logic nb, input string tag);
        bit hit, up;
        model(mode, ch1, ch2, na, nb, hit, up);
        @(negedge clk);
        ch1 = na; ch2 = nb;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk);
        check(cnt_stb == 1'b0, {tag, " R7 early strobe"}, cnt_stb, 0);
        @(posedge clk);
        @(negedge clk);
        check(cnt_stb == hit, {tag, " strobe"}, cnt_stb, hit);
        if (hit && cnt_stb) begin
            check(cnt_up == up, {tag, " R6 direction"}, cnt_up, up);
            pos += cnt_up ? 1 : -1;
        end
        @(negedge clk);
        check(cnt_stb == 1'b0, {tag, " R7 one-cycle width"}, cnt_stb, 0);
    endtask

    task automatic settle(input logic na, input logic nb);
        @(negedge clk); mode = 2'b00; ch1 = na;
        repeat (LAT + 1) @(negedge clk);
        ch2 = nb;
        repeat (LAT + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cnt_stb == 0, "R1 strobe after reset", cnt_stb, 0);
        check(cnt_up == 0, "R1 dir after reset", cnt_up, 0);
        check(err_flag == 0, "R1 err after reset", err_flag, 0);

        // Sweep every mode, start state and single-channel move.
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 2; k++) begin
                    logic sa, sb, ta, tb;
                    sa = s[1]; sb = s[0];
                    ta = (k == 0) ? ~sa : sa;
                    tb = (k == 1) ? ~sb : sb;
                    settle(sa, sb);
                    mode = m[1:0];
                    step(ta, tb, mode_tag(m[1:0]));
                end
            end
        end
        check(err_flag == 0, "R8 no error on single moves", err_flag, 0);

        // Position tracking in 4x mode.
        settle(1'b0, 1'b0);
        mode = 2'b11;
        pos = 0;
        for (int r = 0; r < 2; r++) begin
            step(1, 0, "R10 fwd"); step(1, 1, "R10 fwd");
            step(0, 1, "R10 fwd"); step(0, 0, "R10 fwd");
        end
        check(pos == 8, "R10 forward position", pos, 8);
        step(0, 1, "R10 rev"); step(1, 1, "R10 rev");
        step(1, 0, "R10 rev"); step(0, 0, "R10 rev");
        check(pos == 4, "R10 net position", pos, 4);

        // Channel 2 only over two forward cycles: four up counts.
        mode = 2'b01;
        pos = 0;
        for (int r = 0; r < 2; r++) begin
            step(1, 0, "R2 rot"); step(1, 1, "R2 rot");
            step(0, 1, "R2 rot"); step(0, 0, "R2 rot");
        end
        check(pos == 4, "R2 rotation count", pos, 4);

        // Double change: dropped and flagged.
        mode = 2'b11;
        check(err_flag == 0, "R8 err clear before", err_flag, 0);
        step(1, 1, "R8 double");
        check(err_flag == 1, "R8 err set", err_flag, 1);
        step(1, 0, "R9 later move");
        check(err_flag == 1, "R9 err sticky", err_flag, 1);
        step(0, 1, "R8 double again");
        check(err_flag == 1, "R9 err still set", err_flag, 1);

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(err_flag == 0, "R1 reset clears error", err_flag, 0);
        check(cnt_stb == 0, "R1 reset strobe low", cnt_stb, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule